// File: doc/BRIEF.md
# Double to int32 wrapping converter

This block turns an IEEE 754 binary floating-point operand (double precision by default) into a signed two's-complement integer, following the conversion rules used by JavaScript engines. The fractional part is always discarded toward zero. A magnitude too large for the integer width is not clamped. Instead, its low integer bits are kept, which is the value modulo 2^INT_W. A negative operand is then negated in two's complement modulo 2^INT_W.

A single register stage holds the result. A valid strobe goes in beside the operand and a matching strobe comes out one cycle later. Alongside the result the block reports a four-bit condition vector whose only live bit is an exactness indicator. It also raises an invalid flag for inputs that cannot be represented and an inexact flag for inputs that lost a fraction. The operand format and the integer width are parameters, so a narrow instance can be built for study while the default instance handles 64-bit doubles and 32-bit results.

Top module: `dbl_to_i32_wrap`

## Requirements
- R1: The operand holds the sign in its top bit, then an EXP_W-bit biased exponent (bias 2^(EXP_W-1)-1), then FRAC_W fraction bits in the low positions. For a finite operand whose truncated integer lies in the signed INT_W range, the result is that integer, with the fraction dropped toward zero for both signs.
- R2: For a finite operand whose truncated magnitude does not fit the signed INT_W range, the result is the magnitude modulo 2^INT_W, two's-complement negated modulo 2^INT_W when the sign bit is 1.
- R3: The exactness indicator is 1 only for a finite operand with no discarded fraction whose integer value lies in [-2^(INT_W-1), 2^(INT_W-1)-1]. Otherwise it is 0. When it is 1, neither exception flag is set.
- R4: out_nzcv carries N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. N, C and V are always 0, and Z equals the exactness indicator.
- R5: An all-ones exponent (infinity or NaN) gives result 0, invalid 1, inexact 0 and Z 0.
- R6: A zero exponent gives result 0. With a zero fraction (either sign of zero), no flag is raised and Z is 1. With a nonzero fraction (subnormal), inexact is 1 and Z is 0.
- R7: A finite operand of magnitude at least 2^(FRAC_W+INT_W) gives result 0 and invalid 1, without a shifter wider than FRAC_W+1+INT_W bits.
- R8: Invalid is 1 for every out-of-range finite operand. Inexact is 1 for an in-range operand that lost a fraction. The two flags are never 1 together.
- R9: An operand accepted with in_valid is reflected on the outputs after exactly one clock edge, with out_valid 1. A cycle without in_valid gives out_valid 0 and leaves result and flags unchanged.
- R10: A synchronous active-low reset clears out_valid, the result and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | EXP_W+FRAC_W+1 (64) | Floating-point operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | INT_W (32) | Wrapped, truncated integer |
| out_nzcv | output | 4 | Condition vector {N,Z,C,V} |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The bench builds a second instance with EXP_W=5, FRAC_W=6 and INT_W=8. Its 4096 operand codes are swept completely, and each is compared against a value computed by scaled integer arithmetic. This narrow format exposes every exponent: subnormals, values below one, the exact range edges at -128 and 127, the wrap region, the exponents past the 2^(FRAC_W+INT_W) cutoff, infinities and NaNs. The default double instance is driven with hand-derived vectors at the 32-bit boundaries, including a value just under 2^84 whose lowest significand bit lands on bit 31.

// File: rtl/d2i_pkg.sv
// Shared types for the float-to-integer wrapping converter.
// Assumes nothing beyond SystemVerilog packed types.
package d2i_pkg;

    // Operand classes produced by the unpack stage
    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUBN,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fp_class_e;

    // Conversion status bundled for the output register
    typedef struct packed {
        logic invalid;
        logic inexact;
        logic exact;
    } cvt_flags_t;

endpackage

// File: rtl/d2i_unpack.sv
// Splits a binary floating-point operand into sign, exponent and fraction
// and classifies it. Assumes the sign is in the top bit and the fraction
// is in the low FRAC_W bits. Purely combinational.
module d2i_unpack
    import d2i_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output logic                  sign,
    output logic [EXP_W-1:0]      exp_f,
    output logic [FRAC_W-1:0]     frac_f,
    output fp_class_e             cls
);

    assign sign   = op[EXP_W+FRAC_W];
    assign exp_f  = op[EXP_W+FRAC_W-1:FRAC_W];
    assign frac_f = op[FRAC_W-1:0];

    // Classify from the exponent extremes and the fraction
    always_comb begin
        if (&exp_f) begin
            cls = (|frac_f) ? CLS_NAN : CLS_INF;
        end else if (exp_f == '0) begin
            cls = (|frac_f) ? CLS_SUBN : CLS_ZERO;
        end else begin
            cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/d2i_align.sv
// Aligns the significand of a normal operand so that its integer part
// lands in the low bits, and reports lost fraction and range fit.
// Assumes a normal operand. Exponents below the bias and at or above
// bias+FRAC_W+INT_W are flagged instead of shifted, so the shifter
// never exceeds FRAC_W+1+INT_W bits. Requires INT_W >= 2.
module d2i_align #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 32
) (
    input  logic [EXP_W-1:0]  exp_f,
    input  logic [FRAC_W-1:0] frac_f,
    output logic              below,
    output logic              huge,
    output logic [INT_W-1:0]  mag,
    output logic              lost,
    output logic              fit_pos,
    output logic              fit_neg
);

    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int SPAN   = FRAC_W + INT_W;
    localparam int HUGE_E = BIAS + SPAN;
    localparam int ACC_W  = FRAC_W + 1 + INT_W;
    localparam int SH_W   = $clog2(SPAN + 1);

    logic [31:0]        exp_x;
    logic [SH_W-1:0]    sh;
    logic [ACC_W-1:0]   acc;
    logic [ACC_W-1:0]   ipart;
    logic [ACC_W-1:0]   low_mask;
    logic [FRAC_W:0]    upper;

    assign exp_x = 32'(exp_f);

    // Range gates that keep the shifter bounded
    assign below = exp_x < 32'(BIAS);
    assign huge  = exp_x >= 32'(HUGE_E);

    // Right-shift distance from the scaled significand to the integer part
    assign sh = SH_W'(HUGE_E) - SH_W'(exp_f);

    // Significand with hidden one, pre-scaled by 2^INT_W
    assign acc      = {1'b1, frac_f, {INT_W{1'b0}}};
    assign ipart    = acc >> sh;
    assign low_mask = ~({ACC_W{1'b1}} << sh);

    // Fraction bits dropped by truncation
    assign lost = |(acc & low_mask);

    assign mag   = ipart[INT_W-1:0];
    assign upper = ipart[ACC_W-1:INT_W];

    // Signed-range fit for each sign; negative side admits 2^(INT_W-1)
    assign fit_pos = (upper == '0) && !ipart[INT_W-1];
    assign fit_neg = (upper == '0) && (!ipart[INT_W-1] || (ipart[INT_W-2:0] == '0));

endmodule

// File: rtl/d2i_resolve.sv
// Chooses the final integer and the status flags from the operand class
// and the alignment results, and applies two's-complement negation after
// the magnitude has already been wrapped to INT_W bits. Combinational.
module d2i_resolve
    import d2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  fp_class_e         cls,
    input  logic              sign,
    input  logic              below,
    input  logic              huge,
    input  logic [INT_W-1:0]  mag,
    input  logic              lost,
    input  logic              fit_pos,
    input  logic              fit_neg,
    output logic [INT_W-1:0]  result,
    output cvt_flags_t        flags
);

    logic             fits;
    logic [INT_W-1:0] signed_mag;

    assign fits       = sign ? fit_neg : fit_pos;
    assign signed_mag = sign ? (~mag + INT_W'(1)) : mag;

    // Per-class selection of result and status
    always_comb begin
        result = '0;
        flags  = '0;
        unique case (cls)
            CLS_NAN, CLS_INF: flags.invalid = 1'b1;
            CLS_ZERO:         flags.exact   = 1'b1;
            CLS_SUBN:         flags.inexact = 1'b1;
            default: begin
                if (below) begin
                    flags.inexact = 1'b1;
                end else if (huge) begin
                    flags.invalid = 1'b1;
                end else begin
                    result = signed_mag;
                    if (fits) begin
                        flags.inexact = lost;
                        flags.exact   = !lost;
                    end else begin
                        flags.invalid = 1'b1;
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/dbl_to_i32_wrap.sv
// Floating-point to signed integer converter with truncation toward zero
// and modulo-2^INT_W wraparound. One register stage, synchronous
// active-low reset. Assumes EXP_W >= 2 and INT_W >= 2.
module dbl_to_i32_wrap
    import d2i_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] in_operand,
    output logic                  out_valid,
    output logic [INT_W-1:0]      out_result,
    output logic [3:0]            out_nzcv,
    output logic                  out_invalid,
    output logic                  out_inexact
);

    logic              sign;
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    fp_class_e         cls;
    logic              below;
    logic              huge;
    logic [INT_W-1:0]  mag;
    logic              lost;
    logic              fit_pos;
    logic              fit_neg;
    logic [INT_W-1:0]  result_d;
    cvt_flags_t        flags_d;
    cvt_flags_t        flags_q;

    d2i_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
        .op     (in_operand),
        .sign   (sign),
        .exp_f  (exp_f),
        .frac_f (frac_f),
        .cls    (cls)
    );

    d2i_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
        .exp_f   (exp_f),
        .frac_f  (frac_f),
        .below   (below),
        .huge    (huge),
        .mag     (mag),
        .lost    (lost),
        .fit_pos (fit_pos),
        .fit_neg (fit_neg)
    );

    d2i_resolve #(.INT_W(INT_W)) u_resolve (
        .cls     (cls),
        .sign    (sign),
        .below   (below),
        .huge    (huge),
        .mag     (mag),
        .lost    (lost),
        .fit_pos (fit_pos),
        .fit_neg (fit_neg),
        .result  (result_d),
        .flags   (flags_d)
    );

    // Output strobe follows the input strobe by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture result and flags only for accepted operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            flags_q    <= '0;
        end else if (in_valid) begin
            out_result <= result_d;
            flags_q    <= flags_d;
        end
    end

    assign out_nzcv    = {1'b0, flags_q.exact, 2'b00};
    assign out_invalid = flags_q.invalid;
    assign out_inexact = flags_q.inexact;

endmodule

// File: rtl/dbl_to_i32_wrap_chk.sv
// Protocol and flag-consistency properties for the converter, bound to
// every instance of the top module. Observes ports only.
module dbl_to_i32_wrap_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [EXP_W+FRAC_W-1:0] in_body,
    input logic                    out_valid,
    input logic [INT_W-1:0]        out_result,
    input logic [3:0]              out_nzcv,
    input logic                    out_invalid,
    input logic                    out_inexact
);

    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int HUGE_E = BIAS + FRAC_W + INT_W;

    logic [EXP_W-1:0] ef;
    logic [31:0]      ef_x;
    logic             ef_ones;

    assign ef      = in_body[EXP_W+FRAC_W-1:FRAC_W];
    assign ef_x    = 32'(ef);
    assign ef_ones = &ef;

    assert_nzcv_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_nzcv[3] == 1'b0 && out_nzcv[1:0] == 2'b00));

    assert_exact_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_nzcv[2] |-> (!out_invalid && !out_inexact));

    assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_invalid && out_inexact));

    assert_special_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ef_ones) |=> (out_invalid && out_result == '0 && !out_nzcv[2]));

    assert_zero_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_body == '0) |=> (out_result == '0 && out_nzcv[2]));

    assert_huge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ef_ones && ef_x >= 32'(HUGE_E)) |=> (out_result == '0 && out_invalid));

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result)));

    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_result == '0 && !out_invalid && !out_inexact));

endmodule

bind dbl_to_i32_wrap dbl_to_i32_wrap_chk #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .INT_W  (INT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_body     (in_operand[EXP_W+FRAC_W-1:0]),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_nzcv    (out_nzcv),
    .out_invalid (out_invalid),
    .out_inexact (out_inexact)
);

// File: tb/dbl_to_i32_wrap_tb.sv
module dbl_to_i32_wrap_tb;

    localparam int SE = 5;
    localparam int SF = 6;
    localparam int SN = 8;
    localparam int SW = 1 + SE + SF;
    localparam int SB = (1 << (SE - 1)) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;

    logic          s_vld;
    logic [SW-1:0] s_op;
    logic          s_ov;
    logic [SN-1:0] s_res;
    logic [3:0]    s_nzcv;
    logic          s_inv, s_inx;

    logic          d_vld;
    logic [63:0]   d_op;
    logic          d_ov;
    logic [31:0]   d_res;
    logic [3:0]    d_nzcv;
    logic          d_inv, d_inx;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    dbl_to_i32_wrap #(.EXP_W(SE), .FRAC_W(SF), .INT_W(SN)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(s_vld), .in_operand(s_op),
        .out_valid(s_ov), .out_result(s_res), .out_nzcv(s_nzcv),
        .out_invalid(s_inv), .out_inexact(s_inx)
    );

    dbl_to_i32_wrap u_dut_dbl (
        .clk(clk), .rst_n(rst_n), .in_valid(d_vld), .in_operand(d_op),
        .out_valid(d_ov), .out_result(d_res), .out_nzcv(d_nzcv),
        .out_invalid(d_inv), .out_inexact(d_inx)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference for the narrow format by scaled integer arithmetic
    task automatic ref_small(input logic [SW-1:0] op, output logic [SN-1:0] r,
                             output bit z, output bit inv, output bit inx,
                             output string tag);
        bit     s  = op[SW-1];
        int     e  = int'(op[SW-2:SF]);
        int     f  = int'(op[SF-1:0]);
        longint sc, ip, fr;
        r = '0; z = 0; inv = 0; inx = 0;
        if (e == (1 << SE) - 1) begin
            inv = 1; tag = "R5";
        end else if (e == 0) begin
            tag = "R6";
            if (f == 0) z = 1; else inx = 1;
        end else begin
            sc = longint'(64'((1 << SF) + f)) << e;
            ip = sc >>> (SB + SF);
            fr = sc & ((64'sd1 <<< (SB + SF)) - 1);
            r  = SN'(s ? -ip : ip);
            if (s ? (ip <= (1 << (SN - 1))) : (ip <= (1 << (SN - 1)) - 1)) begin
                tag = "R1";
                if (fr != 0) inx = 1; else z = 1;
            end else begin
                inv = 1;
                tag = (e >= SB + SF + SN) ? "R7" : "R2";
            end
        end
    endtask

    task automatic run_small(input logic [SW-1:0] op);
        logic [SN-1:0] er;
        bit ez, ei, ex;
        string tg;
        @(negedge clk);
        s_op  = op;
        s_vld = 1'b1;
        @(negedge clk);
        ref_small(op, er, ez, ei, ex, tg);
        chk(s_res == er, tg, $sformatf("small result op=%0h", op), 64'(s_res), 64'(er));
        chk({s_nzcv, s_inv, s_inx} == {1'b0, ez, 2'b00, ei, ex}, "R3/R4/R8",
            $sformatf("small flags op=%0h", op),
            64'({s_nzcv, s_inv, s_inx}), 64'({1'b0, ez, 2'b00, ei, ex}));
    endtask

    task automatic run_dbl(input logic [63:0] op, input logic [31:0] er,
                           input bit ez, input bit ei, input bit ex, input string tg);
        @(negedge clk);
        d_op  = op;
        d_vld = 1'b1;
        @(negedge clk);
        chk(d_ov == 1'b1, "R9", "double out_valid", 64'(d_ov), 64'd1);
        chk(d_res == er, tg, $sformatf("double result op=%0h", op), 64'(d_res), 64'(er));
        chk({d_nzcv, d_inv, d_inx} == {1'b0, ez, 2'b00, ei, ex}, "R3/R4/R8",
            $sformatf("double flags op=%0h", op),
            64'({d_nzcv, d_inv, d_inx}), 64'({1'b0, ez, 2'b00, ei, ex}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        s_vld = 1'b0; s_op = '0;
        d_vld = 1'b0; d_op = '0;
        repeat (3) @(negedge clk);
        // R10: state after reset
        chk(s_ov == 0 && s_res == 0 && s_nzcv == 0 && !s_inv && !s_inx, "R10",
            "small reset state", 64'({s_ov, s_res, s_nzcv, s_inv, s_inx}), 64'd0);
        chk(d_ov == 0 && d_res == 0 && d_nzcv == 0 && !d_inv && !d_inx, "R10",
            "double reset state", 64'({d_ov, d_res, d_inv, d_inx}), 64'd0);
        rst_n = 1'b1;

        // Exhaustive sweep of the narrow format (R1, R2, R5, R6, R7)
        for (int i = 0; i < (1 << SW); i++) run_small(SW'(i));

        // R9: hold when no operand is accepted; -34.5 gives -34
        run_small({1'b1, 5'd20, 6'd5});
        @(negedge clk);
        s_vld = 1'b0;
        s_op  = '0;
        @(negedge clk);
        chk(s_ov == 1'b0, "R9", "small idle out_valid", 64'(s_ov), 64'd0);
        chk(s_res == 8'hDE, "R9", "small held result", 64'(s_res), 64'hDE);

        // Double-precision directed vectors
        run_dbl(64'h400E000000000000, 32'h00000003, 0, 0, 1, "R1");
        run_dbl(64'hC00E000000000000, 32'hFFFFFFFD, 0, 0, 1, "R1");
        run_dbl(64'h41DFFFFFFFC00000, 32'h7FFFFFFF, 1, 0, 0, "R1");
        run_dbl(64'hC1E0000000000000, 32'h80000000, 1, 0, 0, "R1");
        run_dbl(64'h41E0000000000000, 32'h80000000, 0, 1, 0, "R2");
        run_dbl(64'h41F0000000500000, 32'h00000005, 0, 1, 0, "R2");
        run_dbl(64'h452FFFFFFFFFFFFF, 32'h80000000, 0, 1, 0, "R2");
        run_dbl(64'h4530000000000000, 32'h00000000, 0, 1, 0, "R7");
        run_dbl(64'h7FF0000000000000, 32'h00000000, 0, 1, 0, "R5");
        run_dbl(64'h7FF8000000000000, 32'h00000000, 0, 1, 0, "R5");
        run_dbl(64'h8000000000000000, 32'h00000000, 1, 0, 0, "R6");
        run_dbl(64'h0000000000000001, 32'h00000000, 0, 0, 1, "R6");
        run_dbl(64'h3FE0000000000000, 32'h00000000, 0, 0, 1, "R1");
        run_dbl(64'hBFF0000000000000, 32'hFFFFFFFF, 1, 0, 0, "R1");

        // R9: hold on the double instance
        @(negedge clk);
        d_vld = 1'b0;
        d_op  = 64'h400E000000000000;
        @(negedge clk);
        chk(d_ov == 1'b0, "R9", "double idle out_valid", 64'(d_ov), 64'd0);
        chk(d_res == 32'hFFFFFFFF && d_nzcv == 4'b0100, "R9", "double held result",
            64'(d_res), 64'hFFFFFFFF);

        // R10: reset while an operand is presented
        run_dbl(64'h41E0000000000000, 32'h80000000, 0, 1, 0, "R2");
        @(negedge clk);
        rst_n = 1'b0;
        d_vld = 1'b1;
        @(negedge clk);
        chk(d_ov == 0 && d_res == 0 && !d_inv && !d_inx && d_nzcv == 0, "R10",
            "double mid-run reset", 64'({d_ov, d_res, d_inv, d_inx}), 64'd0);
        rst_n = 1'b1;
        d_vld = 1'b0;
        @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule